// File: doc/BRIEF.md
# WFI Clock-Gating Wake Controller

This block sits beside a processor cluster and decides when the cluster clock may be switched off while the core waits for an interrupt, and when it must come back on. It watches four inputs: the core's wait-for-interrupt status, a flag from the power sequencer saying the cluster is in its normal running state, a vector of wake sources, and three flit-pending lines from the interconnect receive channels (snoop, response, data). From these it produces a registered clock-gate request and a final clock enable for an external glitch-free gate cell. The clock enable also folds in a separate power-down gate.

The wait status and every wake source arrive from other clock domains. Each passes through its own chain of synchronizer flops before the state machine sees it. The machine has four states. A wake source pulls the cluster out of the gated state through one recovery state. Interconnect traffic pulls it out through another. Both recovery states stay put until the core has left wait-for-interrupt, so a stale wait status cannot re-gate the clock at once. A pending snoop also forces the clock enable high in the same cycle, ahead of the state machine, so the cluster can answer the snoop.

Top module: `wfi_gate_ctrl`

## Requirements
- R1: A synchronous active-high reset puts `gate_state` at NORMAL (0), `gate_req` at 0 and clears every synchronizer flop. After the first clock edge that samples `rst` high, `clk_en` is 1 as long as `pdn_gate` is 0.
- R2: The state encoding is NORMAL=0, GCLOCK=1, AWAKE=2, FLITWAKE=3. From NORMAL the machine moves to GCLOCK when the synchronized wait status is 1, `pwr_idle` is 1, every synchronized wake bit is 0 and no flit is pending. A change on `wfi_in` reaches `gate_state` on the 4th clock edge after it is driven (3 synchronizer stages plus the state register).
- R3: In NORMAL no gating happens while `pwr_idle` is 0 or while any synchronized wake bit is 1.
- R4: Each `wake_in` bit passes through 3 synchronizer stages. In GCLOCK, any nonzero synchronized wake bit moves the machine to AWAKE on the next edge. This move takes priority over a flit that is pending in the same cycle. GCLOCK never returns directly to NORMAL.
- R5: In GCLOCK with no wake bit set, a pending flit on any of `snp_pend`, `rsp_pend` or `dat_pend` moves the machine to FLITWAKE on the next edge. These three lines are not synchronized.
- R6: In GCLOCK, `pwr_idle` falling to 0 moves the machine to AWAKE on the next edge.
- R7: AWAKE and FLITWAKE hold while the synchronized wait status is 1, and move to NORMAL on the edge after it reads 0.
- R8: With `GATE_EN`=1, `gate_req` is a register that holds (state == GCLOCK) from the previous cycle. With `GATE_EN`=0, `gate_req` stays 0 while the state machine still runs.
- R9: `clk_en` = (not `gate_req` and not `pdn_gate`) or `snp_pend`, with no register in the path. A pending snoop ungates the clock in the cycle it appears. Response and data pending lines do not bypass the gate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Cluster-side free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| wfi_in | input | 1 | Core wait-for-interrupt status, asynchronous |
| pwr_idle | input | 1 | Power sequencer is in its normal running state |
| wake_in | input | WAKE_W | Wake sources, asynchronous, any bit wakes |
| snp_pend | input | 1 | Snoop receive channel has a flit pending |
| rsp_pend | input | 1 | Response receive channel has a flit pending |
| dat_pend | input | 1 | Data receive channel has a flit pending |
| pdn_gate | input | 1 | Power-down clock gate from the power sequencer |
| gate_req | output | 1 | Registered wait-for-interrupt clock-gate request |
| clk_en | output | 1 | Final enable for the cluster clock-gate cell |
| gate_state | output | 2 | Current gating state (encoding in R2) |

## Verification
Each result is due at a fixed number of edges after its stimulus. A `wfi_in` or `wake_in` change reaches `gate_state` 4 edges after it is driven and `gate_req` 5 edges after. A flit-pending line or `pwr_idle` reaches `gate_state` after 1 edge and `gate_req` after 2. `clk_en` follows `snp_pend` and `pdn_gate` in the same cycle. The driver applies each stimulus on a falling edge and queues the expected state, gate and enable, tagged with the cycle index in which each is due. The monitor samples shortly after every falling edge and compares an entry only in its due cycle, so checks placed one cycle early also confirm that a result does not appear too soon. The interrupt-over-flit priority is tested by timing a data flit to arrive in the exact cycle the synchronized wake bit appears.

// File: rtl/wgc_pkg.sv
package wgc_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL   = 2'd0,
    ST_GCLOCK   = 2'd1,
    ST_AWAKE    = 2'd2,
    ST_FLITWAKE = 2'd3
  } wgc_state_e;

  localparam int unsigned STATE_W = 2;
endpackage

// File: rtl/wgc_sync.sv
module wgc_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/wgc_fsm.sv
module wgc_fsm
  import wgc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wfi_s,
  input  logic       pwr_idle,
  input  logic       wake_any,
  input  logic       flit_any,
  output wgc_state_e state
);
  wgc_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_NORMAL: begin
        if (wfi_s && pwr_idle && !wake_any && !flit_any) nxt = ST_GCLOCK;
      end
      ST_GCLOCK: begin
        if (wake_any || !pwr_idle) nxt = ST_AWAKE;
        else if (flit_any)         nxt = ST_FLITWAKE;
      end
      ST_AWAKE, ST_FLITWAKE: begin
        if (!wfi_s) nxt = ST_NORMAL;
      end
      default: nxt = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_NORMAL;
    else     state <= nxt;
  end
endmodule

// File: rtl/wgc_gate_out.sv
module wgc_gate_out
  import wgc_pkg::*;
#(
  parameter bit GATE_EN = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  wgc_state_e state,
  input  logic       pdn_gate,
  input  logic       snp_pend,
  output logic       gate_req,
  output logic       clk_en
);
  if (GATE_EN) begin : g_gate
    always_ff @(posedge clk) begin
      if (rst) gate_req <= 1'b0;
      else     gate_req <= (state == ST_GCLOCK);
    end
  end else begin : g_nogate
    always_ff @(posedge clk) begin
      if (rst) gate_req <= 1'b0;
      else     gate_req <= 1'b0;
    end
  end

  assign clk_en = (!gate_req && !pdn_gate) || snp_pend;
endmodule

// File: rtl/wfi_gate_ctrl.sv
module wfi_gate_ctrl
  import wgc_pkg::*;
#(
  parameter int unsigned WAKE_W      = 8,
  parameter int unsigned SYNC_STAGES = 3,
  parameter bit          GATE_EN     = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wfi_in,
  input  logic              pwr_idle,
  input  logic [WAKE_W-1:0] wake_in,
  input  logic              snp_pend,
  input  logic              rsp_pend,
  input  logic              dat_pend,
  input  logic              pdn_gate,
  output logic              gate_req,
  output logic              clk_en,
  output logic [STATE_W-1:0] gate_state
);
  localparam int unsigned SYNC_W = WAKE_W + 1;

  logic [SYNC_W-1:0] sync_q;
  logic              wfi_s;
  logic [WAKE_W-1:0] wake_s;
  logic              wake_any;
  logic              flit_any;
  wgc_state_e        state;

  wgc_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({wfi_in, wake_in}),
    .q   (sync_q)
  );

  assign wfi_s    = sync_q[SYNC_W-1];
  assign wake_s   = sync_q[WAKE_W-1:0];
  assign wake_any = |wake_s;
  assign flit_any = snp_pend | rsp_pend | dat_pend;

  wgc_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .wfi_s    (wfi_s),
    .pwr_idle (pwr_idle),
    .wake_any (wake_any),
    .flit_any (flit_any),
    .state    (state)
  );

  wgc_gate_out #(.GATE_EN(GATE_EN)) u_out (
    .clk      (clk),
    .rst      (rst),
    .state    (state),
    .pdn_gate (pdn_gate),
    .snp_pend (snp_pend),
    .gate_req (gate_req),
    .clk_en   (clk_en)
  );

  assign gate_state = state;
endmodule

// File: rtl/wgc_checker.sv
module wgc_checker #(
  parameter bit GATE_EN = 1'b1
) (
  input logic       clk,
  input logic       rst,
  input logic       pwr_idle,
  input logic       snp_pend,
  input logic       gate_req,
  input logic       clk_en,
  input logic [1:0] gate_state
);
  logic pv = 1'b0;

  always_ff @(posedge clk) begin
    if (rst) pv <= 1'b1;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    (pv && $past(rst)) |-> (gate_state == 2'd0 && !gate_req))
    else $error("reset did not clear state"); // R1

  AST_ENTRY_IDLE: assert property (@(posedge clk) disable iff (rst)
    (pv && !$past(rst) && gate_state == 2'd1 && $past(gate_state) == 2'd0) |-> $past(pwr_idle))
    else $error("gated without idle power state"); // R3

  AST_GCLOCK_EXIT: assert property (@(posedge clk) disable iff (rst)
    (pv && !$past(rst) && $past(gate_state) == 2'd1) |-> (gate_state != 2'd0))
    else $error("gated state returned straight to normal"); // R4

  AST_WAKE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pv && !$past(rst) && $past(gate_state) >= 2'd2) |->
      (gate_state == $past(gate_state) || gate_state == 2'd0))
    else $error("recovery state left to wrong state"); // R7

  AST_GATE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (pv && !$past(rst)) |-> (gate_req == (GATE_EN && $past(gate_state) == 2'd1)))
    else $error("gate request does not follow state"); // R8

  AST_SNOOP_BYPASS: assert property (@(posedge clk) disable iff (rst)
    snp_pend |-> clk_en)
    else $error("snoop did not ungate clock"); // R9

  AST_GATE_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (gate_req && !snp_pend) |-> !clk_en)
    else $error("clock enabled while gated"); // R9
endmodule

bind wfi_gate_ctrl wgc_checker #(.GATE_EN(GATE_EN)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pwr_idle   (pwr_idle),
  .snp_pend   (snp_pend),
  .gate_req   (gate_req),
  .clk_en     (clk_en),
  .gate_state (gate_state)
);

// File: tb/wfi_gate_ctrl_tb.sv
`timescale 1ns/1ps
module wfi_gate_ctrl_tb;
  localparam int WAKE_W = 8;

  logic              clk = 1'b0;
  logic              rst;
  logic              wfi_in, pwr_idle, snp_pend, rsp_pend, dat_pend, pdn_gate;
  logic [WAKE_W-1:0] wake_in;
  logic              gate_req, clk_en, ng_gate, ng_en;
  logic [1:0]        gate_state, ng_state;

  always #2.5 clk = ~clk;

  wfi_gate_ctrl #(.WAKE_W(WAKE_W), .SYNC_STAGES(3), .GATE_EN(1'b1)) u_dut (
    .clk(clk), .rst(rst), .wfi_in(wfi_in), .pwr_idle(pwr_idle), .wake_in(wake_in),
    .snp_pend(snp_pend), .rsp_pend(rsp_pend), .dat_pend(dat_pend), .pdn_gate(pdn_gate),
    .gate_req(gate_req), .clk_en(clk_en), .gate_state(gate_state)
  );

  wfi_gate_ctrl #(.WAKE_W(WAKE_W), .SYNC_STAGES(3), .GATE_EN(1'b0)) u_dut_ng (
    .clk(clk), .rst(rst), .wfi_in(wfi_in), .pwr_idle(pwr_idle), .wake_in(wake_in),
    .snp_pend(snp_pend), .rsp_pend(rsp_pend), .dat_pend(dat_pend), .pdn_gate(pdn_gate),
    .gate_req(ng_gate), .clk_en(ng_en), .gate_state(ng_state)
  );

  typedef struct {
    int    due;
    int    st;
    int    gate;
    int    en;
    int    ng_gate;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   failures = 0;
  bit   finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(input int off, input int st, input int g, input int en,
                      input int ng, input string tag);
    exp_t e;
    e.due = cyc + off; e.st = st; e.gate = g; e.en = en; e.ng_gate = ng; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d cycle=%0d", tag, what, act, exp, cyc);
    end
  endtask

  // monitor: pops expectations in their due cycle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0 && q[0].due <= cyc) begin
        exp_t e;
        e = q.pop_front();
        if (e.due < cyc) begin
          cmp(e.tag, "missed_due", cyc, e.due);
        end else begin
          if (e.st >= 0)      cmp(e.tag, "state", int'(gate_state), e.st);
          if (e.gate >= 0)    cmp(e.tag, "gate_req", int'(gate_req), e.gate);
          if (e.en >= 0)      cmp(e.tag, "clk_en", int'(clk_en), e.en);
          if (e.ng_gate >= 0) cmp(e.tag, "nogate_gate_req", int'(ng_gate), e.ng_gate);
        end
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    wait (cyc >= 5000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    summary();
  end

  initial begin
    rst = 1'b1; wfi_in = 0; pwr_idle = 0; wake_in = '0;
    snp_pend = 0; rsp_pend = 0; dat_pend = 0; pdn_gate = 0;
    step(4);
    rst = 1'b0;
    push(0, 0, 0, 1, 0, "R1 reset state");
    step(2);

    // entry into gating
    wfi_in = 1; pwr_idle = 1;
    push(3, 0, 0, 1, -1, "R2 not before 4 edges");
    push(4, 1, 0, 1, 0, "R2 gclock after 4 edges");
    push(5, 1, 1, 0, 0, "R8 gate one edge later, off when disabled");
    step(6);

    // response flit: no bypass, then FLITWAKE
    rsp_pend = 1;
    push(0, 1, 1, 0, -1, "R9 response does not bypass");
    push(1, 3, 1, 0, -1, "R5 response wake");
    push(2, 3, 0, 1, -1, "R8 gate released");
    step(3);
    rsp_pend = 0;
    step(5);
    push(0, 3, 0, 1, -1, "R7 holds on stale wfi");
    step(1);
    wfi_in = 0;
    push(3, 3, -1, -1, -1, "R7 still held before sync");
    push(4, 0, 0, 1, -1, "R7 back to normal");
    step(6);

    // snoop bypass
    wfi_in = 1;
    step(6);
    push(0, 1, 1, 0, -1, "R2 regated");
    step(1);
    snp_pend = 1;
    push(0, 1, 1, 1, -1, "R9 snoop bypass same cycle");
    push(1, 3, 1, 1, -1, "R5 snoop wake");
    step(2);
    snp_pend = 0; wfi_in = 0;
    step(6);
    push(0, 0, 0, 1, -1, "R7 normal after snoop");
    step(1);

    // interrupt wake
    wfi_in = 1;
    step(6);
    wake_in = 8'h04;
    push(3, 1, 1, 0, -1, "R4 sync delay");
    push(4, 2, 1, 0, -1, "R4 interrupt wake");
    push(5, 2, 0, 1, -1, "R4 clock back");
    step(6);
    wake_in = '0;
    step(6);
    push(0, 2, 0, 1, -1, "R7 awake holds on stale wfi");
    step(1);
    wfi_in = 0;
    step(6);
    push(0, 0, 0, 1, -1, "R7 normal after interrupt");
    step(1);

    // priority: interrupt and flit together
    wfi_in = 1;
    step(6);
    wake_in = 8'h80;
    step(3);
    dat_pend = 1;
    push(1, 2, -1, -1, -1, "R4 interrupt over flit priority");
    step(1);
    dat_pend = 0; wake_in = '0; wfi_in = 0;
    step(6);
    push(0, 0, 0, 1, -1, "R7 normal after priority");
    step(1);

    // R3: wake held blocks gating
    wake_in = 8'h01; wfi_in = 1;
    step(8);
    push(0, 0, 0, 1, -1, "R3 wake held blocks gating");
    step(1);
    wake_in = '0;
    push(4, 1, -1, -1, -1, "R3 gating after wake clears");
    step(6);

    // R6: idle drop while gated
    pwr_idle = 0;
    push(1, 2, -1, -1, -1, "R6 idle drop wakes");
    push(2, 2, 0, 1, -1, "R6 clock back");
    step(3);
    wfi_in = 0;
    step(6);
    wfi_in = 1;
    step(8);
    push(0, 0, 0, 1, -1, "R3 idle low blocks gating");
    step(1);

    // R9: power-down gate
    pdn_gate = 1;
    push(0, 0, 0, 0, -1, "R9 power-down gate");
    step(1);
    snp_pend = 1;
    push(0, 0, 0, 1, -1, "R9 snoop beats power-down");
    step(1);
    snp_pend = 0; pdn_gate = 0;
    step(1);

    // R1: reset while gated
    pwr_idle = 1;
    step(6);
    push(0, 1, 1, 0, 0, "R2 gated before reset");
    step(1);
    rst = 1; wfi_in = 0;
    push(1, 0, 0, 1, 0, "R1 reset from gated");
    step(3);
    rst = 0;
    step(6);
    push(0, 0, 0, 1, -1, "R1 stays normal");
    step(3);

    if (q.size() != 0) cmp("R1", "pending_expectations", q.size(), 0);
    summary();
  end
endmodule